// File: doc/BRIEF.md
# SPI Transmit Queue with Refill Interrupt

This block sits on the transmit side of an SPI master. A host pushes 16-bit words through a write strobe. The block queues them and hands them one at a time to a serial shifter that drives the clock and data lines. The shifter sends the most significant bit first. It runs its serial clock at one quarter of the system clock, so each bit takes four system cycles.

When the shifter is idle and nothing is waiting, a host word skips the queue and goes straight into the shift register. The reported fill count therefore stays at zero. The block always reports how many words are waiting. It keeps a sticky refill flag that sets whenever the fill count is at or below a programmable level, which includes an empty queue. The flag drives an interrupt request when the enable is on. Software uses the request to top the queue up again. The request does not announce arriving data.

A write that meets a full queue is dropped and recorded in a sticky overflow bit.

Top module: `spi_txq_top`

## Requirements
- R1: `fill_count` equals the number of words waiting in the queue, not counting the word being shifted. It is 0 after reset and never exceeds 16.
- R2: When `busy` is low and the queue is empty, a write moves the word into the shifter. On the next cycle `busy` is high and `fill_count` is still 0.
- R3: A write made while the shifter is busy or words are waiting is queued. `fill_count` rises by one in the next cycle, and a second such write brings it to 2.
- R4: A write made while `fill_count` is 16 is dropped and sets `overflow`. `ovf_clr` clears `overflow` in the next cycle, except when a dropped write occurs in the same cycle, in which case the set wins.
- R5: A word is sent over 64 cycles with `busy` high. Each bit lasts four cycles: two with `sclk` low, then two with `sclk` high. Bit 15 is sent first. While `busy` is low, `sclk` and `mosi` are low.
- R6: When `busy` falls and words are waiting, `busy` stays low for exactly one cycle. The head word is then loaded, `busy` rises and `fill_count` drops by one.
- R7: `irq_flag` is 1 after reset. It sets in the cycle after `fill_count` is less than or equal to `irq_level`, and it stays set until it is cleared.
- R8: `flag_clr` forces `irq_flag` to 0 in the next cycle. If the level condition still holds, the flag sets again one cycle later.
- R9: `irq` is high exactly when `irq_flag` is 1 and `irq_enable` is 1.
- R10: Words leave on `mosi` in the order they were accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Host write strobe |
| wr_data | input | 16 | Host write word |
| irq_level | input | 5 | Refill threshold compared with the fill count |
| irq_enable | input | 1 | Lets the refill flag drive `irq` |
| flag_clr | input | 1 | Write-1 clear of the refill flag |
| ovf_clr | input | 1 | Clear of the sticky overflow bit |
| fill_count | output | 5 | Number of queued words |
| overflow | output | 1 | Sticky overflow bit |
| irq_flag | output | 1 | Refill flag |
| irq | output | 1 | Interrupt request |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| busy | output | 1 | Shifter is sending a word |

## Verification
Several properties are checked on every cycle:
- the bound on the fill count and its one-step changes;
- the skip-the-queue path for an idle write;
- the overflow set on a dropped write;
- the flag setting after the level condition and dropping after a clear;
- the serial clock starting low at each word.

Other behaviour is visible only through the bench's scenarios, which it compares against a cycle model:
- the 64-cycle word timing;
- the single idle cycle between queued words;
- the bit order on `mosi`;
- the end-to-end word order;
- how the request follows enable toggles and threshold changes.

// File: rtl/spi_txq_pkg.sv
package spi_txq_pkg;

    typedef enum logic [1:0] {
        LD_NONE  = 2'd0,
        LD_QUEUE = 2'd1,
        LD_HOST  = 2'd2
    } ld_src_e;

    function automatic int unsigned ptr_step(input int unsigned ptr, input int unsigned depth);
        return (ptr == depth - 1) ? 0 : ptr + 1;
    endfunction

endpackage

// File: rtl/spi_txq_store.sv
module spi_txq_store #(
    parameter int unsigned DATA_W = 16,
    parameter int unsigned DEPTH  = 16,
    parameter int unsigned CNT_W  = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              push,
    input  logic [DATA_W-1:0] push_data,
    input  logic              pop,
    output logic [DATA_W-1:0] head,
    output logic [CNT_W-1:0]  count,
    output logic              full,
    output logic              empty
);
    import spi_txq_pkg::*;

    localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic [DATA_W-1:0] mem [DEPTH];
    logic [PTR_W-1:0]  rd_ptr, wr_ptr;
    logic              past_ok;

    assign full  = (count == CNT_W'(DEPTH));
    assign empty = (count == '0);
    assign head  = mem[rd_ptr];

    always_ff @(posedge clk) begin
        if (push) mem[wr_ptr] <= push_data;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_ptr  <= '0;
            wr_ptr  <= '0;
            count   <= '0;
            past_ok <= 1'b0;
        end else begin
            past_ok <= 1'b1;
            if (push) wr_ptr <= PTR_W'(ptr_step(int'(wr_ptr), DEPTH));
            if (pop)  rd_ptr <= PTR_W'(ptr_step(int'(rd_ptr), DEPTH));
            case ({push, pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    p_count_bound_r1: assert property (@(posedge clk) disable iff (rst)
        count <= CNT_W'(DEPTH));

    p_count_step_r3: assert property (@(posedge clk) disable iff (rst)
        past_ok |-> (count == $past(count)) || (count == $past(count) + 1'b1)
                    || (count + 1'b1 == $past(count)));

endmodule

// File: rtl/spi_txq_shifter.sv
module spi_txq_shifter #(
    parameter int unsigned DATA_W = 16,
    parameter int unsigned DIV    = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [DATA_W-1:0] load_data,
    output logic              busy,
    output logic              sclk,
    output logic              mosi
);
    localparam int unsigned DIV_W = $clog2(DIV);
    localparam int unsigned BIT_W = $clog2(DATA_W);
    localparam logic [DIV_W-1:0] HALF     = DIV_W'(DIV / 2);
    localparam logic [DIV_W-1:0] LAST_DIV = DIV_W'(DIV - 1);
    localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(DATA_W - 1);

    logic [DATA_W-1:0] shreg;
    logic [DIV_W-1:0]  phase;
    logic [BIT_W-1:0]  bit_idx;

    assign sclk = busy && (phase >= HALF);
    assign mosi = busy && shreg[DATA_W-1];

    always_ff @(posedge clk) begin
        if (rst) begin
            busy    <= 1'b0;
            shreg   <= '0;
            phase   <= '0;
            bit_idx <= '0;
        end else if (busy) begin
            if (phase == LAST_DIV) begin
                phase <= '0;
                shreg <= {shreg[DATA_W-2:0], 1'b0};
                if (bit_idx == LAST_BIT) begin
                    busy    <= 1'b0;
                    bit_idx <= '0;
                end else begin
                    bit_idx <= bit_idx + 1'b1;
                end
            end else begin
                phase <= phase + 1'b1;
            end
        end else if (load) begin
            busy    <= 1'b1;
            shreg   <= load_data;
            phase   <= '0;
            bit_idx <= '0;
        end
    end

    p_start_low_r5: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> !sclk);

endmodule

// File: rtl/spi_txq_refill.sv
module spi_txq_refill #(
    parameter int unsigned CNT_W = 5
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [CNT_W-1:0] count,
    input  logic [CNT_W-1:0] level,
    input  logic             enable,
    input  logic             flag_clr,
    output logic             flag,
    output logic             irq
);
    logic at_or_below;

    assign at_or_below = (count <= level);
    assign irq         = flag && enable;

    always_ff @(posedge clk) begin
        if (rst)           flag <= 1'b1;
        else if (flag_clr) flag <= 1'b0;
        else if (at_or_below) flag <= 1'b1;
    end

    p_flag_sets_r7: assert property (@(posedge clk) disable iff (rst)
        (!flag_clr && count <= level) |=> flag);

    p_clr_drops_r8: assert property (@(posedge clk) disable iff (rst)
        flag_clr |=> !flag);

endmodule

// File: rtl/spi_txq_top.sv
module spi_txq_top #(
    parameter int unsigned DATA_W = 16,
    parameter int unsigned DEPTH  = 16,
    parameter int unsigned DIV    = 4,
    parameter int unsigned CNT_W  = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [CNT_W-1:0]  irq_level,
    input  logic              irq_enable,
    input  logic              flag_clr,
    input  logic              ovf_clr,
    output logic [CNT_W-1:0]  fill_count,
    output logic              overflow,
    output logic              irq_flag,
    output logic              irq,
    output logic              sclk,
    output logic              mosi,
    output logic              busy
);
    import spi_txq_pkg::*;

    ld_src_e           src;
    logic              push, pop, load, full, empty;
    logic [DATA_W-1:0] head, load_data;

    always_comb begin
        src = LD_NONE;
        if (!busy) begin
            if (!empty)     src = LD_QUEUE;
            else if (wr_en) src = LD_HOST;
        end
    end

    assign pop       = (src == LD_QUEUE);
    assign load      = (src != LD_NONE);
    assign load_data = (src == LD_QUEUE) ? head : wr_data;
    assign push      = wr_en && !full && (src != LD_HOST);

    always_ff @(posedge clk) begin
        if (rst)                overflow <= 1'b0;
        else if (wr_en && full) overflow <= 1'b1;
        else if (ovf_clr)       overflow <= 1'b0;
    end

    spi_txq_store #(.DATA_W(DATA_W), .DEPTH(DEPTH), .CNT_W(CNT_W)) u_store (
        .clk(clk), .rst(rst), .push(push), .push_data(wr_data), .pop(pop),
        .head(head), .count(fill_count), .full(full), .empty(empty)
    );

    spi_txq_shifter #(.DATA_W(DATA_W), .DIV(DIV)) u_shift (
        .clk(clk), .rst(rst), .load(load), .load_data(load_data),
        .busy(busy), .sclk(sclk), .mosi(mosi)
    );

    spi_txq_refill #(.CNT_W(CNT_W)) u_refill (
        .clk(clk), .rst(rst), .count(fill_count), .level(irq_level),
        .enable(irq_enable), .flag_clr(flag_clr), .flag(irq_flag), .irq(irq)
    );

    p_direct_r2: assert property (@(posedge clk) disable iff (rst)
        (!busy && fill_count == '0 && wr_en) |=> (busy && fill_count == '0));

    p_full_drop_r4: assert property (@(posedge clk) disable iff (rst)
        (wr_en && fill_count == CNT_W'(DEPTH)) |=> overflow);

endmodule

// File: tb/spi_txq_top_bench.sv
`timescale 1ns/100ps
module spi_txq_top_bench;
    localparam int QD = 16;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [15:0] wr_data = '0;
    logic [4:0]  irq_level = 5'd2;
    logic        irq_enable = 1'b1;
    logic        flag_clr = 1'b0;
    logic        ovf_clr = 1'b0;
    logic [4:0]  fill_count;
    logic        overflow, irq_flag, irq, sclk, mosi, busy;

    always #2.5 clk = ~clk;

    spi_txq_top u_spi_txq_top (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
        .irq_level(irq_level), .irq_enable(irq_enable), .flag_clr(flag_clr),
        .ovf_clr(ovf_clr), .fill_count(fill_count), .overflow(overflow),
        .irq_flag(irq_flag), .irq(irq), .sclk(sclk), .mosi(mosi), .busy(busy)
    );

    int total = 0;
    int fails = 0;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // behavioural reference model
    logic [15:0] q[$];
    logic [15:0] sent[$];
    logic [15:0] got[$];
    bit          m_busy, m_ovf, m_flag, started;
    int          m_tick;
    logic [15:0] m_word;

    always @(posedge clk) begin
        int  n;
        bit  full, popq, direct, pushq;
        started = 1'b1;
        if (rst) begin
            q.delete(); m_busy = 0; m_tick = 0; m_word = '0; m_ovf = 0; m_flag = 1;
        end else begin
            n      = q.size();
            full   = (n == QD);
            popq   = !m_busy && n > 0;
            direct = !m_busy && n == 0 && wr_en;
            pushq  = wr_en && !full && !direct;
            m_ovf  = (wr_en && full) ? 1'b1 : (ovf_clr ? 1'b0 : m_ovf);
            m_flag = flag_clr ? 1'b0 : (m_flag || n <= int'(irq_level));
            if (m_busy) begin
                if (m_tick == 63) m_busy = 0; else m_tick++;
            end else if (popq) begin
                m_word = q.pop_front(); sent.push_back(m_word); m_busy = 1; m_tick = 0;
            end else if (direct) begin
                m_word = wr_data; sent.push_back(m_word); m_busy = 1; m_tick = 0;
            end
            if (pushq) q.push_back(wr_data);
        end
    end

    always @(negedge clk) begin
        if (started) begin
            chk("R1 fill_count", 32'(fill_count), 32'(q.size()));
            chk("R4 overflow", 32'(overflow), 32'(m_ovf));
            chk("R7 irq_flag", 32'(irq_flag), 32'(m_flag));
            chk("R9 irq", 32'(irq), 32'(m_flag && irq_enable));
            chk("R5 busy", 32'(busy), 32'(m_busy));
            chk("R5 sclk", 32'(sclk), 32'(m_busy && (m_tick % 4) >= 2));
            chk("R5 mosi", 32'(mosi), 32'(m_busy ? m_word[15 - m_tick / 4] : 1'b0));
        end
    end

    // serial sink
    logic [15:0] sink_sr = '0;
    int          sink_n = 0;
    always @(posedge sclk) begin
        sink_sr = {sink_sr[14:0], mosi};
        sink_n++;
        if (sink_n == 16) begin
            got.push_back(sink_sr);
            sink_n = 0;
        end
    end

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic put(input logic [15:0] d);
        wr_en = 1'b1; wr_data = d;
        step(1);
        wr_en = 1'b0;
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        total++; fails++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        step(3);
        rst = 1'b0;
        chk("R1 reset count", 32'(fill_count), 0);
        chk("R7 reset flag", 32'(irq_flag), 1);
        chk("R4 reset overflow", 32'(overflow), 0);
        chk("R5 reset busy", 32'(busy), 0);

        put(16'hA5C3);
        chk("R2 direct busy", 32'(busy), 1);
        chk("R2 direct count", 32'(fill_count), 0);
        put(16'h1234);
        chk("R3 first queued", 32'(fill_count), 1);
        put(16'h8001);
        chk("R3 second queued", 32'(fill_count), 2);

        while (busy) step(1);
        chk("R6 idle gap count", 32'(fill_count), 2);
        step(1);
        chk("R6 reload busy", 32'(busy), 1);
        chk("R6 reload count", 32'(fill_count), 1);
        while (busy || fill_count != 0) step(1);

        irq_level = 5'd0;
        step(1);
        flag_clr = 1'b1; step(1); flag_clr = 1'b0;
        chk("R8 cleared", 32'(irq_flag), 0);
        step(1);
        chk("R8 sets again", 32'(irq_flag), 1);

        for (int i = 0; i < 5; i++) put(16'h0F00 + 16'(i));
        chk("R3 four queued", 32'(fill_count), 4);
        flag_clr = 1'b1; step(1); flag_clr = 1'b0;
        step(3);
        chk("R8 stays clear", 32'(irq_flag), 0);
        chk("R9 irq low", 32'(irq), 0);
        irq_level = 5'd4;
        step(2);
        chk("R7 level raised", 32'(irq_flag), 1);
        irq_enable = 1'b0;
        #0.5 chk("R9 masked", 32'(irq), 0);
        step(1);
        irq_enable = 1'b1;
        #0.5 chk("R9 unmasked", 32'(irq), 1);
        step(1);

        begin
            int k = 0;
            while (fill_count < 5'd16) begin
                put(16'hC000 + 16'(k)); k++;
            end
        end
        chk("R4 full", 32'(fill_count), 16);
        put(16'hDEAD);
        chk("R4 dropped count", 32'(fill_count), 16);
        chk("R4 overflow set", 32'(overflow), 1);
        step(2);
        ovf_clr = 1'b1; step(1); ovf_clr = 1'b0;
        chk("R4 overflow cleared", 32'(overflow), 0);

        while (busy || fill_count != 0) step(1);
        step(4);
        chk("R10 word total", 32'(got.size()), 32'(sent.size()));
        for (int i = 0; i < sent.size() && i < got.size(); i++)
            chk("R10 word order", 32'(got[i]), 32'(sent[i]));
        finish_run();
    end
endmodule